// File: doc/BRIEF.md
# Interval Endpoint Rounding and Scale Synchronizer

This block takes the two 32-bit endpoints of an interval result, together with one overflow flag for each endpoint, and reduces them to 16-bit endpoints. The reduction rounds outward, so the narrow interval always contains the wide one. The lower endpoint is rounded toward minus infinity. The upper endpoint is rounded toward plus infinity. Overflow is handled with conditional block scaling. If either endpoint wrapped, both endpoints are halved together and the block exponent increment is raised by one. If rounding the upper endpoint would pass the largest positive code, both endpoints are halved once more and the increment rises again. Because of this, the two endpoints always leave with the same exponent increment.

A pointwise mode treats the lower input as a single value and leaves the upper input unused. This mode rounds either by truncation or toward plus infinity and applies the same scaling rules. For iterative work, where results feed an accumulator, any scaling event raises a stall for a fixed penalty window. During that window the accumulator path is flushed and reloaded, and new inputs are refused. Alongside the datapath, the block keeps the smallest exponent reported by exponent detection during the current block.

Top module: `ors_scale_sync`

## Requirements
- R1: While reset is asserted and after reset until the first accepted input, `out_valid_o`, `stall_o`, both 16-bit outputs and both update outputs are 0, and `min_exp_o` is all ones.
- R2: In interval mode (`mode_pt_i`=0), with no overflow flag and no upper wrap, `lo_out_o` equals bits 31..16 of `lo_wide_i` (floor of the value divided by 2^16).
- R3: In interval mode, with no overflow and no wrap, `hi_out_o` equals bits 31..16 of `hi_wide_i` plus 1 when any of bits 15..0 is set (ceiling of the value divided by 2^16).
- R4: An overflow flag means its 32-bit input wrapped once, and the true value is the input read as signed plus 2^32 when bit 31 is 1, or minus 2^32 when bit 31 is 0. In interval mode, if either flag is set, both true values are divided by 2^17 (lower floor, upper ceiling) and both update outputs carry at least 1.
- R5: If the upper ceiling after the R3/R4 step would be 0x8000, `hi_out_o` is 0x4000, the lower endpoint is floored at one further halving, and both update outputs rise by one more (total 1 or 2).
- R6: In interval mode, `updt_lo_o` always equals `updt_hi_o`.
- R7: In pointwise mode (`mode_pt_i`=1), the value comes from `lo_wide_i`/`lo_ovf_i` and the upper inputs are ignored. `pt_ceil_i`=0 truncates and `pt_ceil_i`=1 takes the ceiling. The R4 and R5 scaling is applied to this value alone. `hi_out_o` repeats `lo_out_o`, `updt_lo_o` carries the increment, and `updt_hi_o` is 0.
- R8: An input accepted at a clock edge (`in_valid_i`=1 with `stall_o`=0) produces `out_valid_o`=1 with its results after that edge. The result outputs hold their values until the next accepted input.
- R9: An accepted input with `iter_i`=1 and a nonzero increment raises `stall_o` for exactly 3 cycles after its edge, and inputs presented in those cycles are dropped. With `iter_i`=0, no stall is raised.
- R10: `min_exp_o` follows the minimum `det_exp_i` seen on cycles with `det_valid_i`=1. `blk_clr_i` restarts the tracking from all ones, or from that cycle's exponent when `det_valid_i` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Input endpoints present |
| mode_pt_i | input | 1 | 0 interval, 1 pointwise |
| pt_ceil_i | input | 1 | Pointwise rounding: 0 truncate, 1 toward +infinity |
| iter_i | input | 1 | Iterative operation, enables the stall penalty |
| lo_wide_i | input | 32 | Wide lower endpoint (pointwise value) |
| hi_wide_i | input | 32 | Wide upper endpoint |
| lo_ovf_i | input | 1 | Lower endpoint wrapped |
| hi_ovf_i | input | 1 | Upper endpoint wrapped |
| det_valid_i | input | 1 | Detected exponent present |
| det_exp_i | input | 5 | Detected exponent |
| blk_clr_i | input | 1 | Start a new block for minimum tracking |
| out_valid_o | output | 1 | Results updated this cycle |
| lo_out_o | output | 16 | Rounded lower endpoint |
| hi_out_o | output | 16 | Rounded upper endpoint |
| updt_lo_o | output | 2 | Exponent increment, lower |
| updt_hi_o | output | 2 | Exponent increment, upper |
| stall_o | output | 1 | Penalty window, inputs refused |
| min_exp_o | output | 5 | Smallest detected exponent of the block |

## Verification
A wrong choice of scaling shows up one cycle after the input is accepted. It appears either as update outputs that differ between the endpoints, or as an endpoint that is off by a factor of two compared with the arithmetic floor or ceiling of the true value. The sweep pairs upper halves at the edges of the positive range with sticky patterns, so a lost sticky bit or a missed wrap changes `hi_out_o` at once. A miscounted penalty counter shows as a stall window one cycle too long or too short, and as an input that is accepted or dropped when it should not be. A stale minimum register is visible on `min_exp_o` on the cycle after the exponent that should have replaced it.

// File: rtl/ors_pkg.sv
package ors_pkg;
  typedef enum logic {
    ORS_MODE_INTERVAL = 1'b0,
    ORS_MODE_POINT    = 1'b1
  } ors_mode_e;

  localparam int ORS_NUM_EP = 2;
  localparam int ORS_EP_LO  = 0;
  localparam int ORS_EP_HI  = 1;
endpackage

// File: rtl/ors_endpoint.sv
module ors_endpoint #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  wide_i,
  input  logic             own_ovf_i,
  input  logic             halve_i,
  input  logic             ceil_i,
  output logic [OUT_W-1:0] res1_o,
  output logic [OUT_W-1:0] res2_o,
  output logic             wrap_o
);
  localparam int DROP_W = IN_W - OUT_W;
  localparam logic [OUT_W-1:0] MAX_POS = {1'b0, {(OUT_W-1){1'b1}}};

  logic [IN_W-1:0]  stage1;
  logic [IN_W-1:0]  stage2;
  logic             top_bit;
  logic             sticky1;
  logic             sticky2;
  logic [OUT_W-1:0] trunc1;
  logic [OUT_W-1:0] trunc2;

  always_comb begin
    // a wrapped input carries its true sign inverted in the MSB
    top_bit = own_ovf_i ? ~wide_i[IN_W-1] : wide_i[IN_W-1];
    stage1  = halve_i ? {top_bit, wide_i[IN_W-1:1]} : wide_i;
    sticky1 = (|stage1[DROP_W-1:0]) | (halve_i & wide_i[0]);
    trunc1  = stage1[IN_W-1:DROP_W];
    stage2  = {stage1[IN_W-1], stage1[IN_W-1:1]};
    sticky2 = sticky1 | stage1[DROP_W];
    trunc2  = stage2[IN_W-1:DROP_W];
    res1_o  = trunc1 + OUT_W'(ceil_i & sticky1);
    res2_o  = trunc2 + OUT_W'(ceil_i & sticky2);
    wrap_o  = ceil_i & sticky1 & (trunc1 == MAX_POS);
  end
endmodule

// File: rtl/ors_penalty_ctl.sv
module ors_penalty_ctl #(
  parameter int PEN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger_i,
  output logic stall_o
);
  localparam int CNT_W = $clog2(PEN_CYC + 1);
  localparam logic [CNT_W-1:0] PEN_LOAD = CNT_W'(PEN_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (trigger_i)
      cnt_d = PEN_LOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stall_o = (cnt_q != '0);

  AST_PEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trigger_i |=> stall_o); // R9
endmodule

// File: rtl/ors_min_track.sv
module ors_min_track #(
  parameter int EXP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_valid_i,
  input  logic [EXP_W-1:0] det_exp_i,
  input  logic             blk_clr_i,
  output logic [EXP_W-1:0] min_exp_o
);
  logic [EXP_W-1:0] min_q;
  logic [EXP_W-1:0] min_d;
  logic             min_en;

  always_comb begin
    min_en = blk_clr_i | (det_valid_i & (det_exp_i < min_q));
    if (blk_clr_i)
      min_d = det_valid_i ? det_exp_i : '1;
    else
      min_d = det_exp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      min_q <= '1;
    else if (min_en) min_q <= min_d;
  end

  assign min_exp_o = min_q;

  AST_MIN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_clr_i |=> (min_q <= $past(min_q))); // R10
endmodule

// File: rtl/ors_scale_sync.sv
module ors_scale_sync #(
  parameter int IN_W    = 32,
  parameter int OUT_W   = 16,
  parameter int EXP_W   = 5,
  parameter int PEN_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic             mode_pt_i,
  input  logic             pt_ceil_i,
  input  logic             iter_i,
  input  logic [IN_W-1:0]  lo_wide_i,
  input  logic [IN_W-1:0]  hi_wide_i,
  input  logic             lo_ovf_i,
  input  logic             hi_ovf_i,
  input  logic             det_valid_i,
  input  logic [EXP_W-1:0] det_exp_i,
  input  logic             blk_clr_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] lo_out_o,
  output logic [OUT_W-1:0] hi_out_o,
  output logic [1:0]       updt_lo_o,
  output logic [1:0]       updt_hi_o,
  output logic             stall_o,
  output logic [EXP_W-1:0] min_exp_o
);
  import ors_pkg::*;

  localparam logic [OUT_W-1:0] HALF_SCALE = OUT_W'(1) << (OUT_W - 2);

  ors_mode_e        mode;
  logic [IN_W-1:0]  ep_wide [ORS_NUM_EP];
  logic             ep_own  [ORS_NUM_EP];
  logic             ep_ceil [ORS_NUM_EP];
  logic [OUT_W-1:0] ep_res1 [ORS_NUM_EP];
  logic [OUT_W-1:0] ep_res2 [ORS_NUM_EP];
  logic             ep_wrap [ORS_NUM_EP];

  logic             halve;
  logic             wrap_any;
  logic [1:0]       inc;
  logic             accept;
  logic             trigger;
  logic [OUT_W-1:0] lo_d;
  logic [OUT_W-1:0] hi_d;
  logic [1:0]       updt_hi_d;

  logic             valid_q;
  logic             pt_q;
  logic [OUT_W-1:0] lo_q;
  logic [OUT_W-1:0] hi_q;
  logic [1:0]       updt_lo_q;
  logic [1:0]       updt_hi_q;

  assign mode = ors_mode_e'(mode_pt_i);

  always_comb begin
    ep_wide[ORS_EP_LO] = lo_wide_i;
    ep_wide[ORS_EP_HI] = hi_wide_i;
    ep_own[ORS_EP_LO]  = lo_ovf_i;
    ep_own[ORS_EP_HI]  = hi_ovf_i;
    ep_ceil[ORS_EP_LO] = (mode == ORS_MODE_POINT) & pt_ceil_i;
    ep_ceil[ORS_EP_HI] = 1'b1;
    halve = (mode == ORS_MODE_POINT) ? lo_ovf_i : (lo_ovf_i | hi_ovf_i);
  end

  for (genvar g = 0; g < ORS_NUM_EP; g++) begin : g_ep
    ors_endpoint #(
      .IN_W  (IN_W),
      .OUT_W (OUT_W)
    ) ep_i (
      .wide_i    (ep_wide[g]),
      .own_ovf_i (ep_own[g]),
      .halve_i   (halve),
      .ceil_i    (ep_ceil[g]),
      .res1_o    (ep_res1[g]),
      .res2_o    (ep_res2[g]),
      .wrap_o    (ep_wrap[g])
    );
  end

  always_comb begin
    wrap_any = ep_wrap[ORS_EP_LO] |
               ((mode == ORS_MODE_INTERVAL) & ep_wrap[ORS_EP_HI]);
    inc      = {1'b0, halve} + {1'b0, wrap_any};
    lo_d     = wrap_any ? ep_res2[ORS_EP_LO] : ep_res1[ORS_EP_LO];
    if (mode == ORS_MODE_POINT) begin
      hi_d      = lo_d;
      updt_hi_d = 2'd0;
    end else begin
      hi_d      = wrap_any ? ep_res2[ORS_EP_HI] : ep_res1[ORS_EP_HI];
      updt_hi_d = inc;
    end
    accept  = in_valid_i & ~stall_o;
    trigger = accept & iter_i & (inc != 2'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt_q      <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
      updt_lo_q <= 2'd0;
      updt_hi_q <= 2'd0;
    end else if (accept) begin
      pt_q      <= mode_pt_i;
      lo_q      <= lo_d;
      hi_q      <= hi_d;
      updt_lo_q <= inc;
      updt_hi_q <= updt_hi_d;
    end
  end

  ors_penalty_ctl #(
    .PEN_CYC (PEN_CYC)
  ) pen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trigger_i (trigger),
    .stall_o   (stall_o)
  );

  ors_min_track #(
    .EXP_W (EXP_W)
  ) min_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .det_valid_i (det_valid_i),
    .det_exp_i   (det_exp_i),
    .blk_clr_i   (blk_clr_i),
    .min_exp_o   (min_exp_o)
  );

  assign out_valid_o = valid_q;
  assign lo_out_o    = lo_q;
  assign hi_out_o    = hi_q;
  assign updt_lo_o   = updt_lo_q;
  assign updt_hi_o   = updt_hi_q;

  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid_o); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !out_valid_o); // R9
  AST_UPDT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !pt_q) |-> (updt_lo_o == updt_hi_o)); // R6
  AST_WRAP_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wrap_any) |=> ((pt_q ? lo_out_o : hi_out_o) == HALF_SCALE)); // R5
endmodule

// File: tb/ors_scale_sync_tb.sv
`timescale 1ns/1ps
module ors_scale_sync_tb_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid_i;
  logic        mode_pt_i;
  logic        pt_ceil_i;
  logic        iter_i;
  logic [31:0] lo_wide_i;
  logic [31:0] hi_wide_i;
  logic        lo_ovf_i;
  logic        hi_ovf_i;
  logic        det_valid_i;
  logic [4:0]  det_exp_i;
  logic        blk_clr_i;
  logic        out_valid_o;
  logic [15:0] lo_out_o;
  logic [15:0] hi_out_o;
  logic [1:0]  updt_lo_o;
  logic [1:0]  updt_hi_o;
  logic        stall_o;
  logic [4:0]  min_exp_o;

  int n_chk;
  int n_fail;
  bit done;

  ors_scale_sync dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .mode_pt_i(mode_pt_i),
    .pt_ceil_i(pt_ceil_i), .iter_i(iter_i), .lo_wide_i(lo_wide_i),
    .hi_wide_i(hi_wide_i), .lo_ovf_i(lo_ovf_i), .hi_ovf_i(hi_ovf_i),
    .det_valid_i(det_valid_i), .det_exp_i(det_exp_i), .blk_clr_i(blk_clr_i),
    .out_valid_o(out_valid_o), .lo_out_o(lo_out_o), .hi_out_o(hi_out_o),
    .updt_lo_o(updt_lo_o), .updt_hi_o(updt_hi_o), .stall_o(stall_o),
    .min_exp_o(min_exp_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] up_half [8] = '{16'h0000, 16'h0001, 16'h7FFE, 16'h7FFF,
                               16'h8000, 16'hFFFF, 16'h4000, 16'hC123};
  logic [15:0] lo_half [4] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF};

  function automatic longint true_val(logic [31:0] w, logic ovf);
    longint t;
    t = longint'($signed(w));
    if (ovf) t = w[31] ? t + 64'sd4294967296 : t - 64'sd4294967296;
    return t;
  endfunction

  function automatic longint fdiv(longint t, int k);
    return t >>> k;
  endfunction

  function automatic longint cdiv(longint t, int k);
    return -((-t) >>> k);
  endfunction

  logic [15:0] e_lo, e_hi;
  logic [1:0]  e_ul, e_uh;
  string       e_tag;

  task automatic model(input logic [31:0] lw, input logic [31:0] hw,
                       input logic lov, input logic hov,
                       input logic pt, input logic up);
    longint tl, th, rl, rh;
    int sh;
    tl = true_val(lw, lov);
    th = true_val(hw, hov);
    if (!pt) begin
      sh = (lov | hov) ? 17 : 16;
      rh = cdiv(th, sh);
      if (rh > 32767) begin sh++; rh = cdiv(th, sh); end
      rl = fdiv(tl, sh);
      e_lo = rl[15:0]; e_hi = rh[15:0];
      e_ul = 2'(sh - 16); e_uh = e_ul;
      e_tag = (sh == 18 || rh == 16384 && e_ul != 0 && (sh - 16) > int'(lov | hov)) ? "R5" :
              (lov | hov) ? "R4" : "R2_R3";
    end else begin
      sh = lov ? 17 : 16;
      rl = up ? cdiv(tl, sh) : fdiv(tl, sh);
      if (rl > 32767) begin sh++; rl = cdiv(tl, sh); end
      e_lo = rl[15:0]; e_hi = rl[15:0];
      e_ul = 2'(sh - 16); e_uh = 2'd0;
      e_tag = "R7";
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic vec(input logic [31:0] lw, input logic [31:0] hw,
                     input logic lov, input logic hov,
                     input logic pt, input logic up);
    in_valid_i = 1'b1; iter_i = 1'b0;
    lo_wide_i = lw; hi_wide_i = hw; lo_ovf_i = lov; hi_ovf_i = hov;
    mode_pt_i = pt; pt_ceil_i = up;
    model(lw, hw, lov, hov, pt, up);
    @(negedge clk);
    check(e_tag, {out_valid_o, lo_out_o, hi_out_o, updt_lo_o, updt_hi_o},
                 {1'b1, e_lo, e_hi, e_ul, e_uh});
    if (!pt) check("R6", {62'd0, updt_lo_o}, {62'd0, updt_hi_o});
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      report();
    end
  end

  initial begin
    logic [15:0] held;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; in_valid_i = 1'b0; mode_pt_i = 1'b0; pt_ceil_i = 1'b0;
    iter_i = 1'b0; lo_wide_i = '0; hi_wide_i = '0; lo_ovf_i = 1'b0;
    hi_ovf_i = 1'b0; det_valid_i = 1'b0; det_exp_i = '0; blk_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {out_valid_o, stall_o, lo_out_o, hi_out_o, updt_lo_o, updt_hi_o, min_exp_o},
                {1'b0, 1'b0, 16'h0, 16'h0, 2'd0, 2'd0, 5'h1F});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid_o, stall_o, lo_out_o, hi_out_o, min_exp_o},
                {1'b0, 1'b0, 16'h0, 16'h0, 5'h1F});

    // interval sweep: every upper/low half pairing, both flags
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        vec({up_half[(a>>1)&7], lo_half[(a>>4)&3]},
            {up_half[(b>>1)&7], lo_half[(b>>4)&3]}, a[0], b[0], 1'b0, 1'b0);
      end
    end
    // pointwise sweep, upper inputs set to junk that must be ignored
    for (int a = 0; a < 64; a++) begin
      for (int m = 0; m < 2; m++) begin
        vec({up_half[(a>>1)&7], lo_half[(a>>4)&3]}, 32'h8000_0001,
            a[0], 1'b1, 1'b1, m[0]);
      end
    end
    // scattered values
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] r1, r2, r3;
      r1 = $urandom; r2 = $urandom; r3 = $urandom;
      vec(r1, r2, r3[0], r3[1], r3[2], r3[3]);
    end

    // R9: iterative overflow raises a 3-cycle stall, inputs dropped
    in_valid_i = 1'b1; iter_i = 1'b1; mode_pt_i = 1'b0;
    lo_wide_i = 32'h1000_0000; hi_wide_i = 32'h9000_0000;
    lo_ovf_i = 1'b0; hi_ovf_i = 1'b1;
    @(negedge clk);
    check("R9", {out_valid_o, stall_o, updt_lo_o}, {1'b1, 1'b1, 2'd1});
    held = lo_out_o;
    lo_wide_i = 32'h0123_0000; hi_wide_i = 32'h0200_0000;
    hi_ovf_i = 1'b0; iter_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9", {out_valid_o, stall_o, lo_out_o}, {1'b0, (k < 2), held});
    end
    @(negedge clk);
    check("R8", {out_valid_o, stall_o, lo_out_o, hi_out_o},
                {1'b1, 1'b0, 16'h0123, 16'h0200});
    // non-iterative overflow: no stall
    hi_ovf_i = 1'b1; hi_wide_i = 32'h9000_0000;
    @(negedge clk);
    check("R9", {out_valid_o, stall_o}, {1'b1, 1'b0});
    in_valid_i = 1'b0;
    @(negedge clk);
    check("R8", {out_valid_o, lo_out_o}, {1'b0, 16'h0091});

    // R10: minimum detected exponent
    blk_clr_i = 1'b1; det_valid_i = 1'b1; det_exp_i = 5'd9;
    @(negedge clk); check("R10", {59'd0, min_exp_o}, 64'd9);
    blk_clr_i = 1'b0; det_exp_i = 5'd4;
    @(negedge clk); check("R10", {59'd0, min_exp_o}, 64'd4);
    det_exp_i = 5'd7;
    @(negedge clk); check("R10", {59'd0, min_exp_o}, 64'd4);
    det_valid_i = 1'b0; det_exp_i = 5'd1;
    @(negedge clk); check("R10", {59'd0, min_exp_o}, 64'd4);
    blk_clr_i = 1'b1;
    @(negedge clk); check("R10", {59'd0, min_exp_o}, 64'd31);
    blk_clr_i = 1'b0;
    @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule